// File: doc/BRIEF.md
# Dual external interrupt request unit

This block watches two external interrupt pins on behalf of a small microcontroller core. Each pin is first combined with the port output latch bit that belongs to it: the effective level is low when either the pin or that latch bit is low. Each source has its own mode bit that picks one of two detection styles. In level mode the source is flagged on every clock while its effective level is low. In edge mode it is flagged only when that level goes from high to low.

The pending flags are masked by per-source enables and by one global enable. The block presents one request to the core, with the index of the chosen source and that source's fixed vector address. A priority-select input bit per source lifts a source above every source whose bit is clear. Within one priority group the lower-numbered source wins. When the core acknowledges the request, an edge-mode flag clears itself. A level-mode flag does not clear on acknowledge. Software reads and writes the mode, flag and enable bits through a small register port.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset every flag, enable and mode bit reads 0, `irq_o` is low, and the stored previous level of each input is high.
- R2: With the mode bit at 0 (level), a source's flag is set at every clock edge at which its effective input is low. It is visible in the cycle after that edge, even if software cleared it while the input stays low.
- R3: With the mode bit at 1 (edge), a flag is set only at the edge where the stored previous effective level is high and the current one is low. An input held low after a software clear does not set it again.
- R4: The effective input of source i is `pin_i[i] & latch_i[i]`, so a low latch bit acts exactly like a low pin.
- R5: When `irq_o` is high, `irq_vec_o` is 0x0003 for source 0 and 0x0013 for source 1 (base 0x0003 plus 0x10 per index), and `irq_src_o` gives the index.
- R6: `irq_o` is high only when at least one source has its flag, its enable bit and the global enable all set.
- R7: With equal priority-select bits, source 0 is chosen over source 1 when both are active.
- R8: A source whose `prio_i` bit is 1 is chosen over any active source whose bit is 0.
- R9: An acknowledge (`ack_i` high while `irq_o` is high) clears the flag of the presented source if that source is in edge mode. A level-mode flag is left set.
- R10: A register write is seen in the read value from the following cycle. If a write to the flag register and a hardware set land on the same clock edge, the flag ends up set.
- R11: Register map, 8-bit data. Address 0 holds the mode bits in bits [1:0]. Address 1 holds the flags in bits [1:0]. Address 2 holds the per-source enables in bits [1:0] and the global enable in bit 7. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 2 | External interrupt pins |
| latch_i | input | 2 | Port output latch bits, one per pin |
| prio_i | input | 2 | Priority-select bit per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| ack_i | input | 1 | Core acknowledge of the presented request |
| irq_o | output | 1 | Request to the core |
| irq_src_o | output | 1 | Index of the presented source |
| irq_vec_o | output | 16 | Vector address of the presented source |

## Verification
The bench goes after the cases where the detection styles differ: an input held low after a software clear. A design that treats edge mode like level mode would raise the flag again at once. A design that treats level mode like edge mode would leave it clear. It also drops the latch bit while the pin stays high, which an edge detector that ignores the latch would miss. It lands a software clear on the same edge as a hardware set, where the wrong ordering loses an interrupt. Finally it acknowledges one source of each mode, and swaps priority bits with both sources pending, which exposes an inverted fixed order or a priority bit that is ignored.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int DW       = 8;
  localparam int AW       = 2;
  localparam int GEN_BIT  = DW - 1;

  typedef enum logic [AW-1:0] {
    A_MODE = 2'd0,
    A_FLAG = 2'd1,
    A_ENAB = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // Set condition for one source: level mode sets while low, edge mode on a fall.
  function automatic logic set_event(input logic edge_mode, input logic prev, input logic eff);
    return edge_mode ? (prev & ~eff) : ~eff;
  endfunction

  // Vector address of source idx.
  function automatic logic [15:0] vec_of(input logic [15:0] base, input logic [15:0] step,
                                         input int idx);
    return base + step * 16'(idx);
  endfunction

endpackage

// File: rtl/ext_irq_detect.sv
module ext_irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_eff,
  input  logic edge_mode,
  input  logic sw_we,
  input  logic sw_val,
  input  logic ack_hit,
  output logic flag,
  output logic hw_set,
  output logic prev_lvl
);
  import ext_irq_pkg::*;

  assign hw_set = set_event(edge_mode, prev_lvl, pin_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= 1'b1;
      flag     <= 1'b0;
    end else begin
      prev_lvl <= pin_eff;
      if (hw_set)                 flag <= 1'b1;
      else if (sw_we)             flag <= sw_val;
      else if (ack_hit && edge_mode) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs #(
  parameter int NSRC = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ext_irq_pkg::AW-1:0]    addr,
  input  logic [ext_irq_pkg::DW-1:0]    wdata,
  input  logic [NSRC-1:0]               flags,
  output logic [NSRC-1:0]               mode,
  output logic [NSRC-1:0]               en,
  output logic                          gen,
  output logic                          flag_we,
  output logic [ext_irq_pkg::DW-1:0]    rdata
);
  import ext_irq_pkg::*;

  logic spare_unused;
  assign spare_unused = ^wdata;

  assign flag_we = we && (addr == A_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      en   <= '0;
      gen  <= 1'b0;
    end else if (we) begin
      if (addr == A_MODE) mode <= wdata[NSRC-1:0];
      if (addr == A_ENAB) begin
        en  <= wdata[NSRC-1:0];
        gen <= wdata[GEN_BIT];
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MODE:  rdata[NSRC-1:0] = mode;
      A_FLAG:  rdata[NSRC-1:0] = flags;
      A_ENAB: begin
        rdata[NSRC-1:0] = en;
        rdata[GEN_BIT]  = gen;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter #(
  parameter int NSRC = 2,
  parameter int SW   = 1
) (
  input  logic [NSRC-1:0] active,
  input  logic [NSRC-1:0] prio,
  output logic            any,
  output logic [SW-1:0]   sel
);
  logic best_prio;

  // Ascending scan: a later source replaces the choice only if strictly higher.
  always_comb begin
    any       = 1'b0;
    sel       = '0;
    best_prio = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!any || (prio[i] && !best_prio))) begin
        any       = 1'b1;
        sel       = SW'(i);
        best_prio = prio[i];
      end
    end
  end

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
  parameter int          NSRC     = 2,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0010,
  localparam int         SW       = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            pin_i,
  input  logic [NSRC-1:0]            latch_i,
  input  logic [NSRC-1:0]            prio_i,
  input  logic                       reg_we,
  input  logic [ext_irq_pkg::AW-1:0] reg_addr,
  input  logic [ext_irq_pkg::DW-1:0] reg_wdata,
  output logic [ext_irq_pkg::DW-1:0] reg_rdata,
  input  logic                       ack_i,
  output logic                       irq_o,
  output logic [SW-1:0]              irq_src_o,
  output logic [15:0]                irq_vec_o
);
  import ext_irq_pkg::*;

  logic [NSRC-1:0] pin_eff, flag, hw_set, prev_lvl, mode, en, active, ack_hit;
  logic            gen, flag_we;

  assign pin_eff = pin_i & latch_i;

  ext_irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .flags(flag), .mode(mode), .en(en), .gen(gen), .flag_we(flag_we), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign ack_hit[g] = ack_i && irq_o && (irq_src_o == SW'(g));
    ext_irq_detect u_det (
      .clk(clk), .rst_n(rst_n), .pin_eff(pin_eff[g]), .edge_mode(mode[g]),
      .sw_we(flag_we), .sw_val(reg_wdata[g]), .ack_hit(ack_hit[g]),
      .flag(flag[g]), .hw_set(hw_set[g]), .prev_lvl(prev_lvl[g])
    );
  end

  assign active = flag & en & {NSRC{gen}};

  ext_irq_arbiter #(.NSRC(NSRC), .SW(SW)) u_arb (
    .active(active), .prio(prio_i), .any(irq_o), .sel(irq_src_o)
  );

  assign irq_vec_o = vec_of(VEC_BASE, VEC_STEP, int'(irq_src_o));

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int          NSRC     = 2,
  parameter int          SW       = 1,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0010
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic [SW-1:0]   irq_src_o,
  input logic [15:0]     irq_vec_o,
  input logic            gen,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] flag,
  input logic [NSRC-1:0] hw_set,
  input logic [NSRC-1:0] prev_lvl,
  input logic [NSRC-1:0] pin_eff,
  input logic [NSRC-1:0] mode,
  input logic [NSRC-1:0] prio_i,
  input logic            ack_i,
  input logic            flag_we
);

  // R6
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (gen && |(flag & en)));

  // R5
  vec_src0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src_o == SW'(0)) |-> irq_vec_o == VEC_BASE);

  // R5
  vec_src1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src_o == SW'(1)) |-> irq_vec_o == VEC_BASE + VEC_STEP);

  // R7
  fixed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen && flag[0] && en[0] && (prio_i[0] || !prio_i[1])) |-> (irq_o && irq_src_o == SW'(0)));

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R10
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set[i] |=> flag[i]);

    // R3
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] && !flag_we && !flag[i] && !(prev_lvl[i] && !pin_eff[i])) |=> !flag[i]);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && irq_src_o == SW'(i) && mode[i] && !hw_set[i] && !flag_we) |=> !flag[i]);
  end

endmodule

bind ext_irq_unit ext_irq_chk #(.NSRC(NSRC), .SW(SW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .irq_src_o(irq_src_o), .irq_vec_o(irq_vec_o),
  .gen(gen), .en(en), .flag(flag), .hw_set(hw_set), .prev_lvl(prev_lvl), .pin_eff(pin_eff),
  .mode(mode), .prio_i(prio_i), .ack_i(ack_i), .flag_we(flag_we)
);

// File: tb/tb_ext_irq_unit.sv
module tb_ext_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_i = 2'b11, latch_i = 2'b11, prio_i = 2'b00;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [0:0] irq_src_o;
  logic [15:0] irq_vec_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .latch_i(latch_i), .prio_i(prio_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_i(ack_i), .irq_o(irq_o), .irq_src_o(irq_src_o), .irq_vec_o(irq_vec_o)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    check(d == exp, req, 16'(d), 16'(exp));
  endtask

  task automatic expect_irq(input bit req_exp, input logic src, input string req);
    check(irq_o == req_exp, req, 16'(irq_o), 16'(req_exp));
    if (req_exp) begin
      check(irq_src_o == src, req, 16'(irq_src_o), 16'(src));
      check(irq_vec_o == (src ? 16'h0013 : 16'h0003), req, irq_vec_o,
            src ? 16'h0013 : 16'h0003);
    end
  endtask

  task automatic t_reset;
    expect_reg(2'd0, 8'h00, "R1 mode");
    expect_reg(2'd1, 8'h00, "R1 flags");
    expect_reg(2'd2, 8'h00, "R1 enables");
    expect_reg(2'd3, 8'h00, "R11 unused addr");
    check(irq_o == 1'b0, "R1 irq", 16'(irq_o), 16'd0);
  endtask

  task automatic t_level;
    wr(2'd2, 8'h81);
    expect_reg(2'd2, 8'h81, "R11 enable readback");
    pin_i[0] = 1'b0;
    tick(1);
    expect_reg(2'd1, 8'h01, "R2 level set");
    expect_irq(1'b1, 1'b0, "R5 src0 vector");
    wr(2'd1, 8'h00);                 // clear lands on an edge with hw set
    expect_reg(2'd1, 8'h01, "R10 hw set wins");
    tick(2);
    expect_reg(2'd1, 8'h01, "R2 re-set while low");
    pin_i[0] = 1'b1;
    tick(1);
    wr(2'd1, 8'h00);
    expect_reg(2'd1, 8'h00, "R10 write next cycle");
    expect_irq(1'b0, 1'b0, "R6 no flag");
  endtask

  task automatic t_global;
    wr(2'd2, 8'h02);                 // src1 enabled, global off
    pin_i[1] = 1'b0;
    tick(1);
    pin_i[1] = 1'b1;
    expect_reg(2'd1, 8'h02, "R2 src1 level");
    expect_irq(1'b0, 1'b0, "R6 global off");
    wr(2'd2, 8'h80);                 // global on, src1 masked
    expect_irq(1'b0, 1'b0, "R6 source disabled");
    wr(2'd2, 8'h82);
    expect_irq(1'b1, 1'b1, "R5 src1 vector");
    wr(2'd1, 8'h00);
  endtask

  task automatic t_edge;
    wr(2'd0, 8'h01);
    expect_reg(2'd0, 8'h01, "R11 mode readback");
    wr(2'd2, 8'h81);
    pin_i[0] = 1'b0;
    tick(1);
    expect_reg(2'd1, 8'h01, "R3 fall sets");
    wr(2'd1, 8'h00);
    tick(3);
    expect_reg(2'd1, 8'h00, "R3 held low no set");
    pin_i[0] = 1'b1;
    tick(1);
    pin_i[0] = 1'b0;
    tick(1);
    expect_reg(2'd1, 8'h01, "R3 second fall");
    pin_i[0] = 1'b1;
    wr(2'd1, 8'h00);
  endtask

  task automatic t_latch;
    wr(2'd0, 8'h03);
    latch_i[1] = 1'b0;               // pin stays high
    tick(1);
    expect_reg(2'd1, 8'h02, "R4 latch low acts as fall");
    latch_i[1] = 1'b1;
    wr(2'd1, 8'h00);
    tick(1);
    expect_reg(2'd1, 8'h00, "R4 latch rise no set");
  endtask

  task automatic t_ack;
    wr(2'd0, 8'h01);                 // src0 edge, src1 level
    wr(2'd2, 8'h81);
    pin_i[0] = 1'b0;
    tick(1);
    pin_i[0] = 1'b1;
    expect_irq(1'b1, 1'b0, "R9 before ack");
    ack_i = 1'b1;
    tick(1);
    ack_i = 1'b0;
    expect_reg(2'd1, 8'h00, "R9 edge ack clears");
    expect_irq(1'b0, 1'b0, "R9 request gone");
    wr(2'd2, 8'h82);
    pin_i[1] = 1'b0;
    tick(1);
    pin_i[1] = 1'b1;
    expect_irq(1'b1, 1'b1, "R9 level pending");
    ack_i = 1'b1;
    tick(1);
    ack_i = 1'b0;
    expect_reg(2'd1, 8'h02, "R9 level ack keeps");
    wr(2'd1, 8'h00);
  endtask

  task automatic t_order;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h83);
    pin_i = 2'b00;
    tick(1);
    prio_i = 2'b00;
    #0.5;
    expect_irq(1'b1, 1'b0, "R7 equal prio src0 first");
    prio_i = 2'b10;
    #0.5;
    expect_irq(1'b1, 1'b1, "R8 src1 raised");
    prio_i = 2'b11;
    #0.5;
    expect_irq(1'b1, 1'b0, "R7 both raised src0 first");
    prio_i = 2'b01;
    #0.5;
    expect_irq(1'b1, 1'b0, "R8 src0 raised");
    pin_i = 2'b11;
    prio_i = 2'b00;
    tick(1);
    wr(2'd1, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_level();
    t_global();
    t_edge();
    t_latch();
    t_ack();
    t_order();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule